// File: doc/BRIEF.md
# Parallel Video Timing Generator

This block produces the raster timing for a parallel pixel output. One clock is one pixel. Each line runs through four phases in order: sync pulse, back porch, active pixels, front porch. A frame runs through the same four phases, counted in lines. From these counters the block drives horizontal sync, vertical sync and data-enable. It also reports the coordinates of the active pixel being shown.

Software describes the raster with three packed 32-bit words. The size word carries the active width and height. Each of the two per-axis timing words carries the sync length, back porch and front porch of its axis. The block holds a private copy of these words and refreshes that copy only between frames.

The pixel source faces a valid/ready stream. `pix_ready` is high in every active pixel cycle, and a pixel is taken whenever `pix_ready` and `pix_valid` are both high. The display cannot wait, so the source gets no back-pressure in the other direction. A cycle in which `pix_ready` is high and `pix_valid` is low is a starved pixel, and it raises the underflow event. The vsync and frame-done events are single-cycle pulses meant for an interrupt controller.

Top module: `video_timing_gen`

## Requirements
- R1: The size word carries the active width (pixels per line) in bits 15:0 and the active height (lines per frame) in bits 31:16.
- R2: The horizontal timing word carries the sync length in bits 7:0, the back porch in bits 19:8 and the front porch in bits 31:20. A line is sync, then back porch, then the active width, then front porch. `hsync` is high (active high) exactly during the sync cycles.
- R3: The vertical timing word uses the same bit fields, counted in lines. A frame is ordered the same way as a line. `vsync` is high during every cycle of the sync lines.
- R4: `de` and `pix_ready` are high only when both axes are inside their active region. `x_pos` and `y_pos` then give the zero-based active column and row, and both read 0 whenever `de` is low.
- R5: `vsync_evt` is a one-cycle pulse on the first cycle of every frame, including the first frame after `run` rises.
- R6: `frame_done` is a one-cycle pulse on the last cycle of every frame.
- R7: `underflow` pulses one cycle after each cycle in which `pix_ready` is high and `pix_valid` is low. It stays low when the source keeps up.
- R8: While running, changes to the three configuration words take effect only from the first cycle of the next frame. While `run` is low, the held copy follows the inputs.
- R9: While `run` is low, both counters are held at zero and `hsync`, `vsync`, `de`, `pix_ready` and the events are all low. The next frame starts from its first cycle when `run` rises again.
- R10: During and straight after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables raster generation |
| panel_size | input | 32 | Packed active height and width |
| h_timing | input | 32 | Packed horizontal sync, back porch and front porch |
| v_timing | input | 32 | Packed vertical sync, back porch and front porch |
| pix_valid | input | 1 | Pixel source has a pixel ready |
| pix_ready | output | 1 | Display takes a pixel this cycle |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| x_pos | output | 16 | Active column |
| y_pos | output | 16 | Active row |
| vsync_evt | output | 1 | Start-of-frame pulse |
| frame_done | output | 1 | End-of-frame pulse |
| underflow | output | 1 | Starved-pixel pulse |

## Verification
The bench samples the first and last active column, a pixel in the front porch and the wrap from the last cycle of one frame into the next. A field decoded at the wrong offset, or an off-by-one region edge, moves `de` or the sync pulses by a cycle at exactly these points. A horizontal word is rewritten in the middle of a frame. A design that loads it at once reshapes the current frame, and the bench catches this before the boundary. A starved source must raise underflow only for active pixels, one cycle late. Dropping `run` must clear the counters so that the frame restarts at its first cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int WORD_W    = 32;
  localparam int SYNC_W    = 8;
  localparam int PORCH_W   = 12;
  localparam int SIZE_W    = 16;
  localparam int SYNC_LSB  = 0;
  localparam int BACK_LSB  = 8;
  localparam int FRONT_LSB = 20;
  localparam int CNT_W     = SIZE_W + 2;
  localparam int N_AXES    = 2;

  typedef struct packed {
    logic [SYNC_W-1:0]  sync_len;
    logic [PORCH_W-1:0] back;
    logic [SIZE_W-1:0]  act;
    logic [PORCH_W-1:0] front;
  } axis_cfg_t;

  // Combine one packed timing word with that axis's active length.
  function automatic axis_cfg_t unpack_axis(input logic [WORD_W-1:0] tw,
                                            input logic [SIZE_W-1:0] act_len);
    axis_cfg_t c;
    c.sync_len = tw[SYNC_LSB  +: SYNC_W];
    c.back     = tw[BACK_LSB  +: PORCH_W];
    c.front    = tw[FRONT_LSB +: PORCH_W];
    c.act      = act_len;
    return c;
  endfunction
endpackage

// File: rtl/vtg_cfg_hold.sv
module vtg_cfg_hold
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] size_word,
  input  logic [WORD_W-1:0] h_word,
  input  logic [WORD_W-1:0] v_word,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg
);
  logic [N_AXES-1:0][WORD_W-1:0] t_words;
  logic [N_AXES-1:0][SIZE_W-1:0] act_len;
  axis_cfg_t                     held [N_AXES];

  assign t_words[0] = h_word;
  assign t_words[1] = v_word;
  assign act_len[0] = size_word[SIZE_W-1:0];
  assign act_len[1] = size_word[2*SIZE_W-1:SIZE_W];

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held[g] <= '0;
      else if (load) held[g] <= unpack_axis(t_words[g], act_len[g]);
    end
  end

  assign h_cfg = held[0];
  assign v_cfg = held[1];
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  axis_cfg_t         cfg,
  output logic [CNT_W-1:0]  pos,
  output logic              last,
  output logic              in_sync,
  output logic              in_active,
  output logic [SIZE_W-1:0] idx
);
  logic [CNT_W-1:0] act_start, act_end, total, offs;

  assign act_start = CNT_W'(cfg.sync_len) + CNT_W'(cfg.back);
  assign act_end   = act_start + CNT_W'(cfg.act);
  assign total     = act_end + CNT_W'(cfg.front);
  assign last      = (pos + 1'b1) >= total;
  assign in_sync   = pos < CNT_W'(cfg.sync_len);
  assign in_active = (pos >= act_start) && (pos < act_end);
  assign offs      = pos - act_start;
  assign idx       = in_active ? offs[SIZE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (!run) pos <= '0;
    else if (step) pos <= last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] panel_size,
  input  logic [WORD_W-1:0] h_timing,
  input  logic [WORD_W-1:0] v_timing,
  input  logic              pix_valid,
  output logic              pix_ready,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [SIZE_W-1:0] x_pos,
  output logic [SIZE_W-1:0] y_pos,
  output logic              vsync_evt,
  output logic              frame_done,
  output logic              underflow
);
  axis_cfg_t        h_cfg, v_cfg;
  logic [CNT_W-1:0] h_pos, v_pos;
  logic             h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic [SIZE_W-1:0] h_idx, v_idx;
  logic             frame_end, cfg_load, uf_q;

  assign frame_end = run & h_last & v_last;
  assign cfg_load  = ~run | frame_end;

  vtg_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .size_word(panel_size), .h_word(h_timing), .v_word(v_timing),
    .h_cfg(h_cfg), .v_cfg(v_cfg)
  );

  vtg_axis u_h (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .cfg(h_cfg),
    .pos(h_pos), .last(h_last), .in_sync(h_sync), .in_active(h_act), .idx(h_idx)
  );

  vtg_axis u_v (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_last), .cfg(v_cfg),
    .pos(v_pos), .last(v_last), .in_sync(v_sync), .in_active(v_act), .idx(v_idx)
  );

  assign hsync      = run & h_sync;
  assign vsync      = run & v_sync;
  assign de         = run & h_act & v_act;
  assign pix_ready  = de;
  assign x_pos      = de ? h_idx : '0;
  assign y_pos      = de ? v_idx : '0;
  assign vsync_evt  = run & (h_pos == '0) & (v_pos == '0);
  assign frame_done = frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= pix_ready & ~pix_valid;
  end
  assign underflow = uf_q;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [SIZE_W-1:0] x_pos,
  input logic              vsync_evt,
  input logic              frame_done,
  input logic              underflow
);
  // R4: active video never overlaps a sync pulse
  a_r4_de_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R4: the column advances by one across consecutive active pixels
  a_r4_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && x_pos != '0) |-> (x_pos == $past(x_pos) + 1'b1));

  // R9: no output activity while stopped
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && !pix_ready && !hsync && !vsync && !vsync_evt && !frame_done));

  // R5 / R6: a new frame opens right after the last one closes
  a_r5_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (vsync_evt || !run));

  // R7: underflow follows exactly a starved active cycle
  a_r7_uf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(pix_ready && !pix_valid));
  a_r7_uf_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> underflow);
endmodule

bind video_timing_gen vtg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .hsync(hsync), .vsync(vsync), .de(de),
  .x_pos(x_pos), .vsync_evt(vsync_evt), .frame_done(frame_done),
  .underflow(underflow)
);

// File: tb/sim_video_timing_gen.sv
module sim_video_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] panel_size, h_timing, v_timing;
  logic        pix_valid = 1'b1;
  logic        pix_ready, hsync, vsync, de, vsync_evt, frame_done, underflow;
  logic [15:0] x_pos, y_pos;
  int          checks = 0;
  int          failures = 0;
  int          cur = 0;

  // Fields: sync 7:0, back 19:8, front 31:20; size height 31:16, width 15:0
  localparam logic [31:0] SIZE_A = 32'h0003_0004; // 4 wide, 3 high
  localparam logic [31:0] HT_A   = 32'h0010_0302; // hs 2, hbp 3, hfp 1 -> 10/line
  localparam logic [31:0] VT_A   = 32'h0010_0201; // vs 1, vbp 2, vfp 1 -> 7 lines
  localparam logic [31:0] HT_B   = 32'h0010_0101; // hs 1, hbp 1, hfp 1 -> 7/line

  // {pos[23:16], hs, vs, de, done, evt, 3'b0, x[7:4], y[3:0]}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0,  5'b11001, 3'b0, 4'd0, 4'd0},
    {8'd5,  5'b01000, 3'b0, 4'd0, 4'd0},
    {8'd30, 5'b10000, 3'b0, 4'd0, 4'd0},
    {8'd35, 5'b00100, 3'b0, 4'd0, 4'd0},
    {8'd38, 5'b00100, 3'b0, 4'd3, 4'd0},
    {8'd39, 5'b00000, 3'b0, 4'd0, 4'd0},
    {8'd46, 5'b00100, 3'b0, 4'd1, 4'd1},
    {8'd58, 5'b00100, 3'b0, 4'd3, 4'd2},
    {8'd65, 5'b00000, 3'b0, 4'd0, 4'd0},
    {8'd69, 5'b00010, 3'b0, 4'd0, 4'd0},
    {8'd70, 5'b11001, 3'b0, 4'd0, 4'd0},
    {8'd71, 5'b11000, 3'b0, 4'd0, 4'd0}
  };

  always #2 clk = ~clk;

  video_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .panel_size(panel_size),
    .h_timing(h_timing), .v_timing(v_timing), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .hsync(hsync), .vsync(vsync), .de(de),
    .x_pos(x_pos), .y_pos(y_pos), .vsync_evt(vsync_evt),
    .frame_done(frame_done), .underflow(underflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cur++;
  endtask

  task automatic goto(input int p);
    while (cur < p) tick();
  endtask

  task automatic start_frame();
    run = 1'b0;
    tick(); tick();
    run = 1'b1;
    #1;
    cur = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    panel_size = SIZE_A;
    h_timing   = HT_A;
    v_timing   = VT_A;
    #1;
    // R10: reset state
    chk("R10 hsync", hsync, 0);
    chk("R10 de", de, 0);
    chk("R10 underflow", underflow, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R9 idle vsync", vsync, 0);
    chk("R9 idle evt", vsync_evt, 0);

    // R1 R2 R3 R4 R5 R6: table walk through one frame and the wrap
    start_frame();
    for (int i = 0; i < NV; i++) begin
      goto(int'(VEC[i][23:16]));
      chk("R2 hsync", hsync, int'(VEC[i][15]));
      chk("R3 vsync", vsync, int'(VEC[i][14]));
      chk("R4 de", de, int'(VEC[i][13]));
      chk("R4 pix_ready", pix_ready, int'(VEC[i][13]));
      chk("R6 frame_done", frame_done, int'(VEC[i][12]));
      chk("R5 vsync_evt", vsync_evt, int'(VEC[i][11]));
      chk("R1 x_pos", x_pos, int'(VEC[i][7:4]));
      chk("R1 y_pos", y_pos, int'(VEC[i][3:0]));
    end

    // R7: starved source only flagged for active pixels, one cycle late
    pix_valid = 1'b0;
    start_frame();
    goto(35);
    chk("R7 none before active", underflow, 0);
    goto(36);
    chk("R7 starved pixel", underflow, 1);
    goto(39);
    chk("R7 last active", underflow, 1);
    goto(40);
    chk("R7 porch clean", underflow, 0);
    pix_valid = 1'b1;
    goto(47);
    chk("R7 source keeps up", underflow, 0);

    // R8: mid-frame rewrite waits for the frame boundary
    start_frame();
    goto(20);
    h_timing = HT_B;
    goto(35);
    chk("R8 old timing de", de, 1);
    chk("R8 old timing x", x_pos, 0);
    goto(69);
    chk("R8 old frame end", frame_done, 1);
    goto(70);
    chk("R8 new frame evt", vsync_evt, 1);
    goto(93);
    chk("R8 new timing de", de, 1);
    chk("R8 new timing x", x_pos, 0);
    chk("R8 new timing y", y_pos, 0);
    chk("R8 new timing hsync", hsync, 0);
    h_timing = HT_A;

    // R9: stopping clears outputs and restarts from frame start
    start_frame();
    goto(40);
    chk("R9 running hsync", hsync, 1);
    run = 1'b0;
    #1;
    chk("R9 stopped hsync", hsync, 0);
    chk("R9 stopped de", de, 0);
    tick();
    run = 1'b1;
    #1;
    chk("R9 restart evt", vsync_evt, 1);
    chk("R9 restart vsync", vsync, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule